// File: doc/BRIEF.md
# MDIO Management Bus Master

This block runs single management transactions against an external PHY register over the two-wire management bus. It generates the management clock (MDC) from the system clock and drives the data line (MDIO) through a split output, an output enable and an input. A host starts a transaction with a one-cycle request pulse and supplies the direction, the 5-bit PHY address, the 5-bit register address and, for a write, 16 bits of data. When the transaction ends the block returns a one-cycle done pulse, the read data and an error flag.

Every frame begins with a full 32-bit preamble of driven ones. A write ends with one extra clock with the line released. A read checks the turnaround bit that the PHY drives. When that bit is low, the block shifts in 16 data bits and adds one released trailing clock. When it reads high, the block clocks 32 further released cycles to flush the PHY, discards them, and reports all-ones data with the error flag set.

Clock timing is set by two parameters given in system clock cycles: `HALF_CYC` sets the MDC low time of every bit and the high time of driven bits; `SAMPLE_CYC` (not smaller than `HALF_CYC`) sets the high time of released bits, and the line is sampled at the end of that time.

Top module: `mdio_master`

## Requirements
- R1: After reset and between transactions, MDC is low, the MDIO output enable is low, and busy and done are low.
- R2: A frame opens with exactly 32 clocks in which MDIO is driven to 1.
- R3: After the preamble, the block drives 0 then 1, then the opcode (1,0 for a read, 0,1 for a write), then the PHY address and then the register address, each 5 bits and most significant bit first.
- R4: A write then drives 1, 0 and the 16 data bits MSB first (64 driven bits in total), followed by exactly one clock with the output enable low. Done then reports an error flag of 0.
- R5: A read releases MDIO after the register address (46 driven bits) and samples the turnaround. If that bit is 0, the block samples 16 data bits MSB first and gives one more released clock (18 released clocks in total). Done then returns the sampled data with the error flag at 0.
- R6: If the read turnaround is sampled as 1, the block gives exactly 32 more released clocks (33 released in total), returns 16'hFFFF and raises the error flag with done. The next successful transaction clears the flag.
- R7: Each bit has an MDC low time of HALF_CYC cycles. A driven bit has an MDC high time of HALF_CYC cycles. A released bit has a high time of SAMPLE_CYC cycles, and MDIO is sampled at the end of that time. A transaction therefore lasts 2*HALF_CYC cycles per driven bit plus HALF_CYC+SAMPLE_CYC cycles per released bit.
- R8: MDIO data and output enable change only while MDC is low or at its falling edge, never during a high phase.
- R9: Busy rises on the cycle after an accepted request and falls on the cycle the one-cycle done pulse appears. Requests that arrive while busy is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Start pulse, taken only when idle |
| req_rd | input | 1 | 1 selects a read, 0 a write |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Data to write |
| rsp_rdata | output | 16 | Read data, valid with done |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Turnaround failure, valid with done |
| busy | output | 1 | Transaction in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value when driven |
| mdio_oe | output | 1 | MDIO drive enable |
| mdio_i | input | 1 | Sampled MDIO line |

## Verification
The test captures the frame at each MDC rise with a PHY model in the bench. Writes with opposite address and data patterns (alternating bits, all-high PHY address with register zero) show whether bit order and field placement are right. Reads return data with only the end bits set and with only the end bits clear, which shows whether the shift direction and sample alignment are right. A read whose turnaround is held high, with zeros offered afterwards, separates the flush path from a normal read, and the read after it shows whether the error flag clears. A request issued during a write shows whether the block ignores requests while busy.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;

    localparam int PRE_BITS   = 32;
    localparam int FLUSH_BITS = 32;
    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 16;
    localparam int FRAME_W    = 4 + 2 * ADDR_W + 2 + DATA_W;
    localparam int RD_TX_BITS = 4 + 2 * ADDR_W;
    localparam int CNT_W      = $clog2(FRAME_W);

    localparam logic [1:0] SOF_PAT = 2'b01;
    localparam logic [1:0] OP_RD   = 2'b10;
    localparam logic [1:0] OP_WR   = 2'b01;
    localparam logic [1:0] TA_WR   = 2'b10;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE,
        S_SEND,
        S_TA,
        S_RECV,
        S_FLUSH,
        S_TAIL
    } mdio_state_e;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
        logic [DATA_W-1:0] wdata;
    } mdio_req_t;

    function automatic logic [FRAME_W-1:0] build_frame(input mdio_req_t r);
        if (r.rd)
            return {SOF_PAT, OP_RD, r.phy, r.regad, {(2 + DATA_W){1'b0}}};
        return {SOF_PAT, OP_WR, r.phy, r.regad, TA_WR, r.wdata};
    endfunction

    function automatic logic [CNT_W-1:0] last_send_idx(input logic rd);
        return rd ? CNT_W'(RD_TX_BITS - 1) : CNT_W'(FRAME_W - 1);
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
`timescale 1ns/1ps
module mdio_clkgen #(
    parameter int HALF_CYC   = 50,
    parameter int SAMPLE_CYC = 70
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic long_high,
    output logic mdc,
    output logic bit_end
);
    localparam int MAXC = (SAMPLE_CYC > HALF_CYC) ? SAMPLE_CYC : HALF_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;
    logic          hi;
    logic [CW-1:0] hi_last;

    assign hi_last = long_high ? CW'(SAMPLE_CYC - 1) : CW'(HALF_CYC - 1);
    assign bit_end = run && hi && (cnt == hi_last);
    assign mdc     = hi;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            hi  <= 1'b0;
        end else if (!hi) begin
            if (cnt == CW'(HALF_CYC - 1)) begin
                cnt <= '0;
                hi  <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else if (cnt == hi_last) begin
            cnt <= '0;
            hi  <= 1'b0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_seq.sv
`timescale 1ns/1ps
module mdio_seq
    import mdio_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      req,
    input  mdio_req_t req_q,
    input  logic      bit_end,
    input  logic      mdio_i,
    output logic      run,
    output logic      long_high,
    output logic      mdio_o,
    output logic      mdio_oe,
    output logic      shift_en,
    output logic      fin,
    output logic      fin_err,
    output logic      fin_rd
);
    mdio_state_e        state;
    logic [CNT_W-1:0]   cnt;
    logic [FRAME_W-1:0] sh;
    logic               rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            cnt   <= '0;
            sh    <= '0;
            rd_q  <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (req) begin
                    state <= S_PRE;
                    cnt   <= CNT_W'(PRE_BITS - 1);
                    sh    <= build_frame(req_q);
                    rd_q  <= req_q.rd;
                end
                S_PRE: if (bit_end) begin
                    if (cnt == '0) begin
                        state <= S_SEND;
                        cnt   <= last_send_idx(rd_q);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                S_SEND: if (bit_end) begin
                    sh <= {sh[FRAME_W-2:0], 1'b0};
                    if (cnt == '0)
                        state <= rd_q ? S_TA : S_TAIL;
                    else
                        cnt <= cnt - 1'b1;
                end
                S_TA: if (bit_end) begin
                    if (mdio_i) begin
                        state <= S_FLUSH;
                        cnt   <= CNT_W'(FLUSH_BITS - 1);
                    end else begin
                        state <= S_RECV;
                        cnt   <= CNT_W'(DATA_W - 1);
                    end
                end
                S_RECV: if (bit_end) begin
                    if (cnt == '0) state <= S_TAIL;
                    else           cnt   <= cnt - 1'b1;
                end
                S_FLUSH: if (bit_end) begin
                    if (cnt == '0) state <= S_IDLE;
                    else           cnt   <= cnt - 1'b1;
                end
                S_TAIL: if (bit_end) state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        run       = (state != S_IDLE);
        mdio_oe   = (state == S_PRE) || (state == S_SEND);
        mdio_o    = (state == S_PRE) || ((state == S_SEND) && sh[FRAME_W-1]);
        long_high = run && !mdio_oe;
        shift_en  = bit_end && (state == S_RECV);
        fin       = bit_end && ((state == S_TAIL) ||
                                ((state == S_FLUSH) && (cnt == '0)));
        fin_err   = (state == S_FLUSH);
        fin_rd    = rd_q;
    end
endmodule

// File: rtl/mdio_rxcap.sv
`timescale 1ns/1ps
module mdio_rxcap
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              din,
    input  logic              fin,
    input  logic              fin_err,
    input  logic              fin_rd,
    output logic [DATA_W-1:0] rdata,
    output logic              done,
    output logic              err
);
    logic [DATA_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            rdata <= '0;
            done  <= 1'b0;
            err   <= 1'b0;
        end else begin
            done <= fin;
            if (shift_en)
                shreg <= {shreg[DATA_W-2:0], din};
            if (fin) begin
                err <= fin_err;
                if (fin_rd)
                    rdata <= fin_err ? {DATA_W{1'b1}} : shreg;
            end
        end
    end
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_CYC   = 50,
    parameter int SAMPLE_CYC = 70
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_rd,
    input  logic [ADDR_W-1:0] req_phy,
    input  logic [ADDR_W-1:0] req_reg,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic              busy,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    mdio_req_t req_q;
    logic run, long_high, bit_end, shift_en, fin, fin_err, fin_rd;

    assign req_q = '{rd: req_rd, phy: req_phy, regad: req_reg, wdata: req_wdata};
    assign busy  = run;

    mdio_clkgen #(.HALF_CYC(HALF_CYC), .SAMPLE_CYC(SAMPLE_CYC)) u_clk (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .long_high (long_high),
        .mdc       (mdc),
        .bit_end   (bit_end)
    );

    mdio_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .req_q     (req_q),
        .bit_end   (bit_end),
        .mdio_i    (mdio_i),
        .run       (run),
        .long_high (long_high),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .shift_en  (shift_en),
        .fin       (fin),
        .fin_err   (fin_err),
        .fin_rd    (fin_rd)
    );

    mdio_rxcap u_rx (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .din      (mdio_i),
        .fin      (fin),
        .fin_err  (fin_err),
        .fin_rd   (fin_rd),
        .rdata    (rsp_rdata),
        .done     (rsp_done),
        .err      (rsp_err)
    );
endmodule

// File: rtl/mdio_master_chk.sv
`timescale 1ns/1ps
module mdio_master_chk #(
    parameter int HALF_CYC   = 50,
    parameter int SAMPLE_CYC = 70
) (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        rsp_done,
    input logic        rsp_err,
    input logic [15:0] rsp_rdata
);
    logic [15:0] hi_len;
    logic [15:0] lo_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_len <= '0;
            lo_len <= '0;
        end else begin
            hi_len <= mdc ? hi_len + 1'b1 : '0;
            lo_len <= (!busy || mdc) ? '0 : lo_len + 1'b1;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mdc && !mdio_oe)); // R1

    AST_PREAMBLE_START: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (mdio_oe && mdio_o)); // R2

    AST_ERR_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && rsp_err) |-> (rsp_rdata == 16'hFFFF)); // R6

    AST_LOW_LEN: assert property (@(posedge clk) disable iff (rst)
        $rose(mdc) |-> (lo_len == 16'(HALF_CYC))); // R7

    AST_HIGH_LEN: assert property (@(posedge clk) disable iff (rst)
        $fell(mdc) |-> (hi_len == 16'(HALF_CYC) || hi_len == 16'(SAMPLE_CYC))); // R7

    AST_LINE_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done); // R9

    AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> rsp_done); // R9
endmodule

bind mdio_master mdio_master_chk #(.HALF_CYC(HALF_CYC), .SAMPLE_CYC(SAMPLE_CYC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .rsp_done  (rsp_done),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata)
);

// File: tb/mdio_master_test.sv
`timescale 1ns/1ps
module mdio_master_test;
    localparam int H = 4;
    localparam int S = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        req_rd = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [4:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic [15:0] rsp_rdata;
    logic        rsp_done, rsp_err, busy, mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_checks = 0;
    int n_fail   = 0;

    logic [63:0] drv_bits;
    int          drv_n, rel_n;
    logic        phy_rd;
    logic [32:0] resp;
    int          busy_cyc, hi_cyc, done_cnt, viol;
    logic        prev_mdc, prev_o, prev_oe;

    always #2.5 clk = ~clk;

    mdio_master #(.HALF_CYC(H), .SAMPLE_CYC(S)) uut (
        .clk(clk), .rst(rst), .req(req), .req_rd(req_rd), .req_phy(req_phy),
        .req_reg(req_reg), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .busy(busy), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY model: capture driven bits, answer on released bits
    always @(posedge mdc) begin
        if (mdio_oe) begin
            drv_bits = {drv_bits[62:0], mdio_o};
            drv_n    = drv_n + 1;
        end else begin
            rel_n = rel_n + 1;
            if (phy_rd) begin
                mdio_i = resp[32];
                resp   = {resp[31:0], 1'b1};
            end
        end
    end

    // line monitor sampled away from the active edge
    always @(negedge clk) begin
        if (busy) busy_cyc = busy_cyc + 1;
        if (mdc) hi_cyc = hi_cyc + 1;
        if (rsp_done) done_cnt = done_cnt + 1;
        if (mdc && prev_mdc && (mdio_o !== prev_o || mdio_oe !== prev_oe))
            viol = viol + 1;
        prev_mdc = mdc;
        prev_o   = mdio_o;
        prev_oe  = mdio_oe;
    end

    task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                       input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic clear_meas(input logic rd, input logic [32:0] r);
        drv_bits = '0; drv_n = 0; rel_n = 0;
        busy_cyc = 0; hi_cyc = 0; done_cnt = 0; viol = 0;
        phy_rd = rd; resp = r; mdio_i = 1'b1;
    endtask

    task automatic issue(input logic rd, input logic [4:0] p, input logic [4:0] r,
                         input logic [15:0] w);
        @(negedge clk);
        req = 1'b1; req_rd = rd; req_phy = p; req_reg = r; req_wdata = w;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic wait_done();
        int t = 0;
        while (!rsp_done && t < 5000) begin
            @(negedge clk);
            t++;
        end
        chk(rsp_done === 1'b1, "R9 done seen", 64'(rsp_done), 64'd1);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(mdc === 1'b0, "R1 mdc idle", 64'(mdc), 64'd0);
        chk(mdio_oe === 1'b0, "R1 oe idle", 64'(mdio_oe), 64'd0);
        chk(busy === 1'b0 && rsp_done === 1'b0, "R1 busy/done idle",
            64'({busy, rsp_done}), 64'd0);
    endtask

    task automatic t_write(input logic [4:0] p, input logic [4:0] r, input logic [15:0] w);
        logic [63:0] exp;
        exp = {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, w};
        clear_meas(1'b0, '1);
        issue(1'b0, p, r, w);
        wait_done();
        chk(drv_n == 64, "R4 driven bit count", 64'(drv_n), 64'd64);
        chk(drv_bits[63:32] == 32'hFFFF_FFFF, "R2 preamble", drv_bits[63:32], 64'hFFFF_FFFF);
        chk(drv_bits[31:18] == exp[31:18], "R3 write header", 64'(drv_bits[31:18]), 64'(exp[31:18]));
        chk(drv_bits[17:0] == exp[17:0], "R4 turnaround and data", 64'(drv_bits[17:0]), 64'(exp[17:0]));
        chk(rel_n == 1, "R4 trailing released clock", 64'(rel_n), 64'd1);
        chk(rsp_err === 1'b0, "R4 error clear", 64'(rsp_err), 64'd0);
        chk(busy_cyc == 64*2*H + H + S, "R7 write duration", 64'(busy_cyc), 64'(64*2*H + H + S));
        chk(hi_cyc == 64*H + S, "R7 write high time", 64'(hi_cyc), 64'(64*H + S));
        chk(viol == 0, "R8 line stable in high phase", 64'(viol), 64'd0);
        chk(done_cnt == 1, "R9 single done", 64'(done_cnt), 64'd1);
        chk(busy === 1'b0 && mdio_oe === 1'b0, "R1 idle after write", 64'({busy, mdio_oe}), 64'd0);
    endtask

    task automatic t_read(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
        logic [45:0] exp;
        exp = {32'hFFFF_FFFF, 2'b01, 2'b10, p, r};
        clear_meas(1'b1, {1'b0, d, 16'hFFFF});
        issue(1'b1, p, r, 16'h0);
        wait_done();
        chk(drv_n == 46, "R5 driven bit count", 64'(drv_n), 64'd46);
        chk(drv_bits[45:0] == exp, "R3 read header", 64'(drv_bits[45:0]), 64'(exp));
        chk(rel_n == 18, "R5 released clock count", 64'(rel_n), 64'd18);
        chk(rsp_rdata == d, "R5 read data", 64'(rsp_rdata), 64'(d));
        chk(rsp_err === 1'b0, "R5 error clear", 64'(rsp_err), 64'd0);
        chk(busy_cyc == 46*2*H + 18*(H+S), "R7 read duration",
            64'(busy_cyc), 64'(46*2*H + 18*(H+S)));
        chk(hi_cyc == 46*H + 18*S, "R7 read high time", 64'(hi_cyc), 64'(46*H + 18*S));
        chk(viol == 0, "R8 line stable in high phase", 64'(viol), 64'd0);
    endtask

    task automatic t_read_bad(input logic [4:0] p, input logic [4:0] r);
        clear_meas(1'b1, {1'b1, 32'h0000_0000});
        issue(1'b1, p, r, 16'h0);
        wait_done();
        chk(rel_n == 33, "R6 flush clock count", 64'(rel_n), 64'd33);
        chk(rsp_rdata == 16'hFFFF, "R6 all-ones data", 64'(rsp_rdata), 64'hFFFF);
        chk(rsp_err === 1'b1, "R6 error set", 64'(rsp_err), 64'd1);
        chk(busy_cyc == 46*2*H + 33*(H+S), "R7 flush duration",
            64'(busy_cyc), 64'(46*2*H + 33*(H+S)));
    endtask

    task automatic t_busy_ignore();
        logic [63:0] exp;
        exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h0C, 5'h03, 2'b10, 16'h1234};
        clear_meas(1'b0, '1);
        issue(1'b0, 5'h0C, 5'h03, 16'h1234);
        repeat (40) @(negedge clk);
        issue(1'b1, 5'h15, 5'h1A, 16'hFFFF);
        wait_done();
        chk(drv_bits == exp && drv_n == 64, "R9 request while busy ignored",
            drv_bits, exp);
        repeat (60) @(negedge clk);
        chk(busy === 1'b0 && done_cnt == 1, "R9 no second transaction",
            64'({busy, 8'(done_cnt)}), 64'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 64'd0, 64'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        clear_meas(1'b0, '1);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        t_write(5'h15, 5'h0A, 16'hA5C3);
        t_write(5'h1F, 5'h00, 16'h0001);
        t_read(5'h12, 5'h0A, 16'h8001);
        t_read(5'h01, 5'h1E, 16'h7FFE);
        t_read_bad(5'h07, 5'h11);
        t_read(5'h07, 5'h11, 16'h3C5A);
        t_busy_ignore();
        t_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule